// File: doc/BRIEF.md
# Link BIST Pattern Generator

This block is the self-test character source on the transmit side of a serial link. It sits in front of the 8B/10B encoder. While self-test is off it registers the host's character stream (eight data bits plus a special-character flag) toward the encoder. It also carries the host path's parity-error indication on its shared progress output.

When self-test is switched on, the host stream is replaced by a repeating pseudo-random sequence of 511 characters. The sequence comes from a 9-bit maximal-length shift register that is reseeded to all ones each time the test is enabled.

Two inputs shape each pass: the receive clocking selection (three levels) and the transmit mode. Together they decide whether a 16-character word-sync burst follows the pseudo-random characters, and whether the progress output is raised for one or for seventeen character clocks when a pass completes. The receive-side checker and the line encoding belong to other blocks.

Top module: `bist_pattern_gen`

## Requirements
- R1: While `rst_n` is low, `out_data`, `out_special` and `progress` are all zero, whatever the host inputs carry.
- R2: With `bist_en` low, `out_data` and `out_special` show `host_data` and `host_special` one clock later, and `progress` shows `host_par_err` one clock later.
- R3: With `bist_en` high, each pseudo-random character is the low 8 bits of a 9-bit register. That register is stepped once per character as next = {s[7:0], s[8]^s[4]}, which is the polynomial x^9 + x^5 + 1. The first character after enable is taken from the all-ones state (0xFF), `out_special` is 0, and 511 characters make one pass, after which the sequence repeats.
- R4: When `rx_clk_sel` is 2'b00 and `tx_mode` is not 2'b00, the 511th pseudo-random character is followed by 16 word-sync characters with `out_special` = 1. The first of these is 0xBC (K28.5) and the other 15 are 0x1C. The next pass then starts again at 0xFF.
- R5: In every other mode combination (`rx_clk_sel` 2'b01, 2'b10 or 2'b11, or `tx_mode` 2'b00), no word-sync characters are sent and the next pass follows the 511th character immediately.
- R6: `progress` rises in the cycle in which the 511th pseudo-random character of a pass appears on the outputs.
- R7: The pass pulse lasts one clock when `rx_clk_sel` is 2'b01, or when `tx_mode` is 2'b00.
- R8: The pass pulse lasts seventeen clocks when `rx_clk_sel` is 2'b00, 2'b10 or 2'b11 and `tx_mode` is not 2'b00. When word-sync is sent, this span covers the 511th character and all 16 sync characters.
- R9: Dropping `bist_en` returns host data and `host_par_err` to the outputs on the next clock and cuts off any pass pulse in flight. Enabling again restarts from the all-ones seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bist_en | input | 1 | Self-test enable |
| rx_clk_sel | input | 2 | Receive clocking selection: 00 low, 01 mid, 10/11 high |
| tx_mode | input | 2 | Transmit mode; 00 is the mode that suppresses word-sync |
| host_data | input | 8 | Host character data |
| host_special | input | 1 | Host special-character flag |
| host_par_err | input | 1 | Parity error from the host input path |
| out_data | output | 8 | Character data toward the encoder |
| out_special | output | 1 | Special-character flag toward the encoder |
| progress | output | 1 | Parity error, or the pass pulse while self-test runs |

## Verification
The end of a pass and a drop of `bist_en` can land on the same stretch of cycles. In low clocking mode, the generator is disabled four characters into the seventeen-clock pulse, while the sync burst is being sent. The bench expects host data and a low `progress` on the very next clock, with `host_par_err` held low so a lingering pulse cannot be mistaken for a parity error. Pass completion and sync emission also overlap by design, and every sync character is judged against a high `progress` in the same cycle.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    typedef enum logic [0:0] {
        PH_PRBS = 1'b0,
        PH_SYNC = 1'b1
    } phase_e;

    localparam logic [1:0] RXC_LOW = 2'b00;
    localparam logic [1:0] RXC_MID = 2'b01;
    localparam logic [1:0] TXM_LL  = 2'b00;

    localparam logic [7:0] SYNC_HEAD = 8'hBC;
    localparam logic [7:0] SYNC_FILL = 8'h1C;

endpackage

// File: rtl/bpg_lfsr_step.sv
module bpg_lfsr_step #(
    parameter int WIDTH = 9,
    parameter int TAP   = 5
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    logic fb;

    generate
        if (WIDTH > 1) begin : g_shift
            always_comb begin
                fb  = cur[WIDTH-1] ^ cur[TAP-1];
                nxt = {cur[WIDTH-2:0], fb};
            end
        end else begin : g_single
            always_comb begin
                fb  = cur[0];
                nxt = cur;
            end
        end
    endgenerate

endmodule

// File: rtl/bpg_mode_decode.sv
module bpg_mode_decode
    import bpg_pkg::*;
(
    input  logic [1:0] rx_clk_sel,
    input  logic [1:0] tx_mode,
    output logic       sync_on,
    output logic       long_pulse
);

    logic tx_plain;

    always_comb begin
        tx_plain   = (tx_mode == TXM_LL);
        sync_on    = (rx_clk_sel == RXC_LOW) && !tx_plain;
        long_pulse = (rx_clk_sel != RXC_MID) && !tx_plain;
    end

endmodule

// File: rtl/bpg_sync_table.sv
module bpg_sync_table
    import bpg_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SYNC_LEN = 16,
    localparam int IDX_W   = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] chr
);

    always_comb begin
        if (idx == '0) chr = DATA_W'(SYNC_HEAD);
        else           chr = DATA_W'(SYNC_FILL);
    end

endmodule

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
    import bpg_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LFSR_W   = 9,
    parameter int LFSR_TAP = 5,
    parameter int SYNC_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bist_en,
    input  logic [1:0]        rx_clk_sel,
    input  logic [1:0]        tx_mode,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_special,
    input  logic              host_par_err,
    output logic [DATA_W-1:0] out_data,
    output logic              out_special,
    output logic              progress
);

    localparam int PASS_LEN = (1 << LFSR_W) - 1;
    localparam int CNT_W    = $clog2(PASS_LEN + 1);
    localparam int SIDX_W   = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
    localparam int LONG_LEN = SYNC_LEN + 1;
    localparam int PLS_W    = $clog2(LONG_LEN + 1);

    typedef struct packed {
        phase_e             phase;
        logic [LFSR_W-1:0]  lfsr;
        logic [CNT_W-1:0]   idx;
        logic [PLS_W-1:0]   pls;
        logic [DATA_W-1:0]  data;
        logic               special;
        logic               prog;
    } state_t;

    state_t st_d, st_q;

    logic [LFSR_W-1:0] lfsr_nxt;
    logic [DATA_W-1:0] sync_chr;
    logic              sync_on;
    logic              long_pulse;
    logic              pass_end;

    bpg_lfsr_step #(
        .WIDTH (LFSR_W),
        .TAP   (LFSR_TAP)
    ) i_lfsr_step (
        .cur (st_q.lfsr),
        .nxt (lfsr_nxt)
    );

    bpg_mode_decode i_mode_decode (
        .rx_clk_sel (rx_clk_sel),
        .tx_mode    (tx_mode),
        .sync_on    (sync_on),
        .long_pulse (long_pulse)
    );

    bpg_sync_table #(
        .DATA_W   (DATA_W),
        .SYNC_LEN (SYNC_LEN)
    ) i_sync_table (
        .idx (st_q.idx[SIDX_W-1:0]),
        .chr (sync_chr)
    );

    always_comb begin
        st_d     = st_q;
        pass_end = 1'b0;
        if (!bist_en) begin
            st_d.phase   = PH_PRBS;
            st_d.lfsr    = '1;
            st_d.idx     = '0;
            st_d.pls     = '0;
            st_d.data    = host_data;
            st_d.special = host_special;
            st_d.prog    = host_par_err;
        end else begin
            unique case (st_q.phase)
                PH_PRBS: begin
                    st_d.data    = st_q.lfsr[DATA_W-1:0];
                    st_d.special = 1'b0;
                    st_d.lfsr    = lfsr_nxt;
                    if (st_q.idx == CNT_W'(PASS_LEN - 1)) begin
                        pass_end   = 1'b1;
                        st_d.idx   = '0;
                        st_d.phase = sync_on ? PH_SYNC : PH_PRBS;
                    end else begin
                        st_d.idx = st_q.idx + CNT_W'(1);
                    end
                end
                PH_SYNC: begin
                    st_d.data    = sync_chr;
                    st_d.special = 1'b1;
                    if (st_q.idx == CNT_W'(SYNC_LEN - 1)) begin
                        st_d.idx   = '0;
                        st_d.phase = PH_PRBS;
                    end else begin
                        st_d.idx = st_q.idx + CNT_W'(1);
                    end
                end
                default: st_d.phase = PH_PRBS;
            endcase

            if (pass_end) begin
                st_d.prog = 1'b1;
                st_d.pls  = long_pulse ? PLS_W'(LONG_LEN - 1) : '0;
            end else if (st_q.pls != '0) begin
                st_d.prog = 1'b1;
                st_d.pls  = st_q.pls - PLS_W'(1);
            end else begin
                st_d.prog = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.phase   <= PH_PRBS;
            st_q.lfsr    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data    = st_q.data;
    assign out_special = st_q.special;
    assign progress    = st_q.prog;

    // The shift register never locks up in the all-zero state.
    assert_lfsr_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bist_en |-> (st_q.lfsr != '0));

    // Characters sent during the sync burst are marked as special.
    assert_sync_special_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_en && st_q.phase == PH_SYNC) |=> out_special);

    // The pass pulse starts with the last pseudo-random character.
    assert_pass_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_en && st_q.phase == PH_PRBS && st_q.idx == CNT_W'(PASS_LEN - 1))
        |=> progress);

    // The long pulse spans the whole sync burst.
    assert_sync_in_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_en && st_q.phase == PH_SYNC) |-> progress);

    // Leaving self-test hands the outputs back to the host at once.
    assert_host_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bist_en |=> (out_data == $past(host_data) && progress == $past(host_par_err)));

endmodule

// File: tb/test_bist_pattern_gen.sv
module test_bist_pattern_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bist_en;
    logic [1:0] rx_clk_sel;
    logic [1:0] tx_mode;
    logic [7:0] host_data;
    logic       host_special;
    logic       host_par_err;
    logic [7:0] out_data;
    logic       out_special;
    logic       progress;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [7:0] d;
        logic       sp;
        logic       pr;
        string      tag;
    } exp_t;

    exp_t sb[$];

    logic [8:0] m_lfsr = 9'h1FF;
    int         m_idx = 0;
    bit         m_sync = 1'b0;
    int         m_pls = 0;
    bit         m_prev_en = 1'b0;

    bist_pattern_gen i_bist_pattern_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .bist_en      (bist_en),
        .rx_clk_sel   (rx_clk_sel),
        .tx_mode      (tx_mode),
        .host_data    (host_data),
        .host_special (host_special),
        .host_par_err (host_par_err),
        .out_data     (out_data),
        .out_special  (out_special),
        .progress     (progress)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Driver: applies one character clock of stimulus and queues the result.
    task automatic drive(input bit en, input logic [1:0] sel, input logic [1:0] tm,
                         input logic [7:0] hd, input bit hs, input bit hp);
        exp_t e;
        bit   start;
        @(negedge clk);
        bist_en      = en;
        rx_clk_sel   = sel;
        tx_mode      = tm;
        host_data    = hd;
        host_special = hs;
        host_par_err = hp;
        if (!en) begin
            e.d = hd; e.sp = hs; e.pr = hp;
            e.tag = m_prev_en ? "R9" : "R2";
            m_lfsr = 9'h1FF; m_idx = 0; m_sync = 1'b0; m_pls = 0;
        end else begin
            start = 1'b0;
            if (m_sync) begin
                e.d = (m_idx == 0) ? 8'hBC : 8'h1C;
                e.sp = 1'b1;
                e.tag = "R4";
                m_idx++;
                if (m_idx == 16) begin m_sync = 1'b0; m_idx = 0; end
            end else begin
                e.d = m_lfsr[7:0];
                e.sp = 1'b0;
                e.tag = "R3";
                m_lfsr = {m_lfsr[7:0], m_lfsr[8] ^ m_lfsr[4]};
                m_idx++;
                if (m_idx == 511) begin
                    m_idx = 0;
                    start = 1'b1;
                    m_sync = (sel == 2'b00) && (tm != 2'b00);
                    if (!m_sync) e.tag = "R5";
                end
            end
            if (start) begin
                e.pr = 1'b1;
                if ((sel != 2'b01) && (tm != 2'b00)) begin
                    m_pls = 16; e.tag = "R8";
                end else begin
                    m_pls = 0; e.tag = "R7";
                end
            end else if (m_pls > 0) begin
                e.pr = 1'b1; m_pls--; e.tag = "R8";
            end else begin
                e.pr = 1'b0;
            end
            if (start) e.tag = {e.tag, "+R6"};
        end
        m_prev_en = en;
        sb.push_back(e);
    endtask

    // Monitor: compares each queued expectation after the edge that produced it.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(out_data == e.d, e.tag, "out_data", int'(out_data), int'(e.d));
                check(out_special == e.sp, e.tag, "out_special", int'(out_special), int'(e.sp));
                check(progress == e.pr, e.tag, "progress", int'(progress), int'(e.pr));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic run_bist(input logic [1:0] sel, input logic [1:0] tm, input int n);
        for (int i = 0; i < n; i++)
            drive(1'b1, sel, tm, 8'(i * 7 + 1), i[0], i[1]);
    endtask

    initial begin
        rst_n = 1'b0;
        bist_en = 1'b0;
        rx_clk_sel = 2'b01;
        tx_mode = 2'b01;
        host_data = 8'hA5;
        host_special = 1'b1;
        host_par_err = 1'b1;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: reset holds outputs at zero
        check(out_data == 8'h00, "R1", "out_data", int'(out_data), 0);
        check(out_special == 1'b0, "R1", "out_special", int'(out_special), 0);
        check(progress == 1'b0, "R1", "progress", int'(progress), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: host pass-through, including parity-error forwarding
        for (int i = 0; i < 8; i++)
            drive(1'b0, 2'b01, 2'b01, 8'(i * 37 + 3), i[0], i[1]);

        // R3, R5, R7: mid clocking, no sync, one-clock pulse
        run_bist(2'b01, 2'b01, 1030);
        drive(1'b0, 2'b01, 2'b01, 8'h5A, 1'b0, 1'b1);
        drive(1'b0, 2'b01, 2'b01, 8'h3C, 1'b1, 1'b0);

        // R4, R8: low clocking with word-sync and long pulse, two passes
        run_bist(2'b00, 2'b01, 1058);
        drive(1'b0, 2'b00, 2'b01, 8'h11, 1'b0, 1'b0);

        // R9: disable in the middle of the long pulse and sync burst
        run_bist(2'b00, 2'b10, 515);
        drive(1'b0, 2'b00, 2'b10, 8'h77, 1'b0, 1'b0);
        drive(1'b0, 2'b00, 2'b10, 8'h78, 1'b0, 1'b0);

        // R5, R8: high clocking, no sync, long pulse
        run_bist(2'b10, 2'b01, 1030);
        drive(1'b0, 2'b10, 2'b01, 8'h22, 1'b0, 1'b0);

        // R5, R7: low clocking in the plain transmit mode
        run_bist(2'b00, 2'b00, 1030);
        drive(1'b0, 2'b00, 2'b00, 8'h33, 1'b1, 1'b1);

        // R8: high-code 11 behaves like high clocking
        run_bist(2'b11, 2'b11, 530);
        drive(1'b0, 2'b11, 2'b11, 8'h44, 1'b0, 1'b0);

        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule